// File: doc/BRIEF.md
# Trace Timestamp Source Selector

This block forms the 64-bit timestamp that is attached to trace packets. It takes the value of a free-running physical counter, two offset values (a virtual offset and a physical offset), and a 2-bit source select. From these it derives one of several timebases: the raw counter, the counter less the virtual offset, or the counter less the physical offset.

A sample request captures the selected timebase into an output register. The captured value appears one cycle later, together with a one-cycle valid strobe. The physical-offset timebase exists only when the enhanced-counter feature flag is set. A separate condition forces that offset to zero. When self-hosted trace is disabled, the select field has no effect and the raw counter is always captured. Every subtraction wraps modulo 2^64.

Top module: `trace_ts_select`

## Requirements
- R1: After reset, `tsOut` is zero and `tsValid` is low.
- R2: With self-hosted trace enabled and `tsSelect` = 2'b01, a sample captures `physCount - virtOffset`.
- R3: With self-hosted trace enabled, `tsSelect` = 2'b10, `ecvPresent` high and `forceZeroOff` low, a sample captures `physCount - physOffset`.
- R4: With self-hosted trace enabled, `tsSelect` = 2'b10, `ecvPresent` high and `forceZeroOff` high, the physical offset is treated as zero and a sample captures `physCount`.
- R5: With `tsSelect` = 2'b10 and `ecvPresent` low, a sample captures `physCount`, whatever value `physOffset` has.
- R6: With self-hosted trace enabled and `tsSelect` = 2'b11, a sample captures `physCount`.
- R7: With self-hosted trace enabled and `tsSelect` = 2'b00, a sample captures `physCount`.
- R8: With `selfHostedEn` low, a sample captures `physCount` for every value of `tsSelect` and of both offsets.
- R9: Subtraction wraps modulo 2^64 and never saturates. For example, 5 - 10 gives 2^64 - 5.
- R10: `tsValid` is high in exactly the cycle after a cycle with `sampleReq` high. `tsOut` takes the captured value at that same edge. `tsOut` holds its value in every cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleReq | input | 1 | Capture the selected timebase on this edge |
| physCount | input | 64 | Free-running physical counter value |
| virtOffset | input | 64 | Virtual offset |
| physOffset | input | 64 | Physical offset |
| ecvPresent | input | 1 | Enhanced-counter feature implemented |
| forceZeroOff | input | 1 | Forces the physical offset to zero |
| tsSelect | input | 2 | Timebase select: 00 raw, 01 virtual, 10 physical-offset, 11 raw |
| selfHostedEn | input | 1 | Self-hosted trace enabled; when low the select is ignored |
| tsOut | output | 64 | Registered timestamp |
| tsValid | output | 1 | One-cycle strobe marking a new `tsOut` |

## Verification
The hardest case to reach is the one where both offsets are nonzero and distinct while the design must still output the raw counter. This happens when the select is ignored, when the feature flag is missing, or when the offset is forced to zero. A design that leaks the wrong offset only shows up when that offset is nonzero. The stimulus therefore loads large, distinct values into both offsets for every raw-counter case, and sets up the 2'b10 select in all three flag combinations. Wrap-around is reached by using offsets larger than the counter. Idle cycles between samples show that the output holds.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  localparam int unsigned SelWidth = 2;

  typedef enum logic [SelWidth-1:0] {
    SEL_RAW_LOW  = 2'b00,
    SEL_VIRT     = 2'b01,
    SEL_PHYS_OFS = 2'b10,
    SEL_RAW_HIGH = 2'b11
  } tsSel_e;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic capture;
    logic subVirt;
    logic subPhys;
  } tsStrobes_t;
endpackage

// File: rtl/tsel_ctrl.sv
module tsel_ctrl
  import tsel_pkg::*;
(
  input  logic                sampleReq,
  input  logic [SelWidth-1:0] tsSelect,
  input  logic                selfHostedEn,
  input  logic                ecvPresent,
  input  logic                forceZeroOff,
  output tsStrobes_t          strobes
);
  tsSel_e selMode;

  always_comb begin
    selMode = tsSel_e'(tsSelect);
    strobes = '0;
    strobes.capture = sampleReq;
    if (selfHostedEn) begin
      unique case (selMode)
        SEL_VIRT:     strobes.subVirt = 1'b1;
        SEL_PHYS_OFS: strobes.subPhys = ecvPresent && !forceZeroOff;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/tsel_datapath.sv
module tsel_datapath
  import tsel_pkg::*;
#(
  parameter int unsigned TsWidth = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  tsStrobes_t         strobes,
  input  logic [TsWidth-1:0] physCount,
  input  logic [TsWidth-1:0] virtOffset,
  input  logic [TsWidth-1:0] physOffset,
  output logic [TsWidth-1:0] tsOut,
  output logic               tsValid
);
  logic [TsWidth-1:0] offsetSel;
  logic [TsWidth-1:0] tsNext;

  always_comb begin
    offsetSel = '0;
    if (strobes.subVirt) offsetSel = virtOffset;
    else if (strobes.subPhys) offsetSel = physOffset;
    tsNext = physCount - offsetSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsOut   <= '0;
      tsValid <= 1'b0;
    end else begin
      tsValid <= strobes.capture;
      if (strobes.capture) tsOut <= tsNext;
    end
  end
endmodule

// File: rtl/trace_ts_select.sv
module trace_ts_select
  import tsel_pkg::*;
#(
  parameter int unsigned TsWidth = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleReq,
  input  logic [TsWidth-1:0] physCount,
  input  logic [TsWidth-1:0] virtOffset,
  input  logic [TsWidth-1:0] physOffset,
  input  logic               ecvPresent,
  input  logic               forceZeroOff,
  input  logic [1:0]         tsSelect,
  input  logic               selfHostedEn,
  output logic [TsWidth-1:0] tsOut,
  output logic               tsValid
);
  tsStrobes_t strobes;

  tsel_ctrl u_ctrl (
    .sampleReq    (sampleReq),
    .tsSelect     (tsSelect),
    .selfHostedEn (selfHostedEn),
    .ecvPresent   (ecvPresent),
    .forceZeroOff (forceZeroOff),
    .strobes      (strobes)
  );

  tsel_datapath #(.TsWidth(TsWidth)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .physCount  (physCount),
    .virtOffset (virtOffset),
    .physOffset (physOffset),
    .tsOut      (tsOut),
    .tsValid    (tsValid)
  );
endmodule

// File: rtl/tsel_checker.sv
module tsel_checker #(
  parameter int unsigned TsWidth = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               sampleReq,
  input logic [TsWidth-1:0] physCount,
  input logic [TsWidth-1:0] virtOffset,
  input logic [TsWidth-1:0] physOffset,
  input logic               ecvPresent,
  input logic               forceZeroOff,
  input logic [1:0]         tsSelect,
  input logic               selfHostedEn,
  input logic [TsWidth-1:0] tsOut,
  input logic               tsValid
);
  logic armed;
  always_ff @(posedge clk) armed <= rstN;

  // R10: the strobe follows the request by one cycle
  a_r10_valid_after_req: assert property (@(posedge clk) disable iff (!rstN || !armed)
    sampleReq |=> tsValid);
  a_r10_no_valid_idle: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !sampleReq |=> !tsValid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !sampleReq |=> $stable(tsOut));

  // R8: a disabled select yields the raw counter
  a_r8_disabled_raw: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (sampleReq && !selfHostedEn) |=> tsOut == $past(physCount));

  // R2 and R9: virtual timebase, wrapping subtraction
  a_r2_virtual: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (sampleReq && selfHostedEn && tsSelect == 2'b01)
      |=> tsOut == $past(physCount) - $past(virtOffset));

  // R3: physical offset applied
  a_r3_phys_offset: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (sampleReq && selfHostedEn && tsSelect == 2'b10 && ecvPresent && !forceZeroOff)
      |=> tsOut == $past(physCount) - $past(physOffset));

  // R4 and R5: forced or unsupported physical offset yields the raw counter
  a_r5_no_feature_raw: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (sampleReq && tsSelect == 2'b10 && (!ecvPresent || forceZeroOff))
      |=> tsOut == $past(physCount));

  // R6 and R7: raw selections
  a_r6_raw_select: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (sampleReq && (tsSelect == 2'b11 || tsSelect == 2'b00)) |=> tsOut == $past(physCount));
endmodule

bind trace_ts_select tsel_checker #(.TsWidth(TsWidth)) u_chk (
  .clk(clk), .rstN(rstN), .sampleReq(sampleReq), .physCount(physCount),
  .virtOffset(virtOffset), .physOffset(physOffset), .ecvPresent(ecvPresent),
  .forceZeroOff(forceZeroOff), .tsSelect(tsSelect), .selfHostedEn(selfHostedEn),
  .tsOut(tsOut), .tsValid(tsValid)
);

// File: tb/sim_trace_ts_select.sv
`timescale 1ns/1ps
module sim_trace_ts_select;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleReq = 1'b0;
  logic [63:0] physCount = '0;
  logic [63:0] virtOffset = '0;
  logic [63:0] physOffset = '0;
  logic        ecvPresent = 1'b0;
  logic        forceZeroOff = 1'b0;
  logic [1:0]  tsSelect = 2'b00;
  logic        selfHostedEn = 1'b0;
  logic [63:0] tsOut;
  logic        tsValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  trace_ts_select u0 (
    .clk(clk), .rstN(rstN), .sampleReq(sampleReq), .physCount(physCount),
    .virtOffset(virtOffset), .physOffset(physOffset), .ecvPresent(ecvPresent),
    .forceZeroOff(forceZeroOff), .tsSelect(tsSelect), .selfHostedEn(selfHostedEn),
    .tsOut(tsOut), .tsValid(tsValid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge, then check the result one cycle later
  task automatic doSample(input string req, input logic en, input logic [1:0] sel,
                          input logic ecv, input logic fz, input logic [63:0] pc,
                          input logic [63:0] vo, input logic [63:0] po,
                          input logic [63:0] exp);
    @(negedge clk);
    selfHostedEn = en; tsSelect = sel; ecvPresent = ecv; forceZeroOff = fz;
    physCount = pc; virtOffset = vo; physOffset = po; sampleReq = 1'b1;
    @(negedge clk);
    sampleReq = 1'b0;
    check({req, " value"}, tsOut, exp);
    check({req, " valid"}, {63'd0, tsValid}, 64'd1);
  endtask

  task automatic testReset();
    check("R1 reset value", tsOut, 64'd0);
    check("R1 reset valid", {63'd0, tsValid}, 64'd0);
  endtask

  task automatic testModes();
    doSample("R2", 1'b1, 2'b01, 1'b0, 1'b0, 64'h1000_0000_0000_0500,
             64'h0000_0000_0000_0100, 64'hAAAA, 64'h1000_0000_0000_0400);
    doSample("R3", 1'b1, 2'b10, 1'b1, 1'b0, 64'h0000_0001_0000_0000,
             64'h5555, 64'h0000_0000_1000_0000, 64'h0000_0000_F000_0000);
    doSample("R4", 1'b1, 2'b10, 1'b1, 1'b1, 64'h1234_5678_9ABC_DEF0,
             64'h5555, 64'h0000_0000_1000_0000, 64'h1234_5678_9ABC_DEF0);
    doSample("R5", 1'b1, 2'b10, 1'b0, 1'b0, 64'h0BAD_F00D_0000_0001,
             64'h5555, 64'h0000_0000_1000_0000, 64'h0BAD_F00D_0000_0001);
    doSample("R6", 1'b1, 2'b11, 1'b1, 1'b0, 64'hCAFE_0000_0000_0042,
             64'h7777, 64'h9999, 64'hCAFE_0000_0000_0042);
    doSample("R7", 1'b1, 2'b00, 1'b1, 1'b0, 64'h0000_0000_0000_9000,
             64'h7777, 64'h9999, 64'h0000_0000_0000_9000);
  endtask

  task automatic testDisabled();
    for (int s = 0; s < 4; s++)
      doSample("R8", 1'b0, 2'(s), 1'b1, 1'b0, 64'h4444_0000_0000_0000 + 64'(s),
               64'h1111, 64'h2222, 64'h4444_0000_0000_0000 + 64'(s));
  endtask

  task automatic testWrap();
    doSample("R9 virtual", 1'b1, 2'b01, 1'b0, 1'b0, 64'd5, 64'd10, 64'd0,
             64'hFFFF_FFFF_FFFF_FFFB);
    doSample("R9 physical", 1'b1, 2'b10, 1'b1, 1'b0, 64'd0, 64'd0, 64'd1,
             64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic testHold();
    doSample("R10", 1'b1, 2'b11, 1'b0, 1'b0, 64'h00AB, 64'd0, 64'd0, 64'h00AB);
    @(negedge clk);
    physCount = 64'h1234; tsSelect = 2'b01; virtOffset = 64'h4;
    @(negedge clk);
    check("R10 hold value", tsOut, 64'h00AB);
    check("R10 idle valid", {63'd0, tsValid}, 64'd0);
    // back-to-back requests
    @(negedge clk);
    selfHostedEn = 1'b1; tsSelect = 2'b11; physCount = 64'd100; sampleReq = 1'b1;
    @(negedge clk);
    check("R10 first back-to-back", tsOut, 64'd100);
    physCount = 64'd200;
    @(negedge clk);
    sampleReq = 1'b0;
    check("R10 second back-to-back", tsOut, 64'd200);
    check("R10 second valid", {63'd0, tsValid}, 64'd1);
    @(negedge clk);
    check("R10 valid drops", {63'd0, tsValid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testModes();
    testDisabled();
    testWrap();
    testHold();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule